// File: doc/BRIEF.md
# SPI Master Data Queues with Watermark Interrupt

This block holds the transmit and receive byte queues of an SPI master and presents them to software through a small register file. Software pushes a byte by writing the transmit data register and pops a byte by reading the receive data register. Each data register carries its queue status in bit 31 of the same word, so a single access both moves data and tells software whether the queue could take or give it.

On the serial side the block meets the frame shifter through two valid/ready handshakes. The transmit queue offers its oldest byte, and the receive queue accepts each byte the shifter has assembled. Two programmable threshold registers turn the live queue levels into pending bits. An enable register masks those bits onto a single interrupt line. Register accesses use plain read and write strobes with a word index. Read data appears on `reg_rdata` in the cycle after the read strobe.

Word indices: 0 transmit data, 1 receive data, 2 transmit threshold, 3 receive threshold, 4 interrupt enable, 5 interrupt pending.

Top module: `spi_fifo_regs`

## Requirements
- R1: A write to index 0 pushes `reg_wdata[7:0]` into the transmit queue when it holds fewer than DEPTH (8) bytes. When the queue is full the write is dropped.
- R2: A read of index 0 returns bit 31 set exactly when the transmit queue is full. All other bits read as zero.
- R3: A read of index 1 on a non-empty receive queue returns the oldest byte in bits 7:0 with bit 31 clear, and pops that byte. On an empty queue the read returns 0x80000000 and removes nothing.
- R4: Both queues deliver bytes in arrival order and hold up to 8 entries.
- R5: `tx_valid` is high while the transmit queue is non-empty, with `tx_data` showing its oldest byte, and that byte is removed on a cycle where `tx_valid` and `tx_ready` are both high. `rx_ready` is high while the receive queue is not full, and `rx_data` is stored on a cycle where `rx_valid` and `rx_ready` are both high.
- R6: Pending bit 0 (index 5) is set while the transmit byte count is strictly less than the transmit threshold at index 2.
- R7: Pending bit 1 (index 5) is set while the receive byte count is strictly greater than the receive threshold at index 3.
- R8: `irq` is high exactly when some pending bit has its enable bit set at index 4, using bit 0 for transmit and bit 1 for receive.
- R9: Writes to index 5 have no effect. The pending bits change only as the queue levels change.
- R10: A push and a pop of the same queue in one cycle leave its byte count unchanged.
- R11: After reset both queues are empty, the thresholds and enables are zero, and `irq` is low.
- R12: Reads of indices 2, 3 and 4 return the value last written, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| tx_valid | output | 1 | Transmit byte available to the shifter |
| tx_data | output | DATA_W | Oldest transmit byte |
| tx_ready | input | 1 | Shifter takes the transmit byte |
| rx_valid | input | 1 | Shifter offers a received byte |
| rx_data | input | DATA_W | Received byte |
| rx_ready | output | 1 | Receive queue has room |
| irq | output | 1 | Watermark interrupt |

## Verification
The hardest case to reach is a register push and a shifter pop of the transmit queue landing in the same clock edge while the byte count sits exactly on the threshold. A wrong count then shows only as a pending-bit flip. The bench parks three bytes with the threshold at three, raises `tx_ready` and the write strobe together, and then reads the pending register. It then drains the queue and counts the bytes that come out and checks their order. It also provokes an empty receive read between two pushes, to show that the read removed nothing.

// File: rtl/spiq_pkg.sv
package spiq_pkg;
    localparam int REG_AW   = 3;
    localparam int FLAG_BIT = 31;
    localparam int BIT_TXWM = 0;
    localparam int BIT_RXWM = 1;

    typedef enum logic [REG_AW-1:0] {
        A_TXD  = 3'd0,
        A_RXD  = 3'd1,
        A_TXMK = 3'd2,
        A_RXMK = 3'd3,
        A_IEN  = 3'd4,
        A_IPND = 3'd5
    } reg_addr_e;
endpackage

// File: rtl/spiq_ring.sv
module spiq_ring #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_i,
    input  logic [W-1:0]                 data_i,
    input  logic                         pop_i,
    output logic [W-1:0]                 head_o,
    output logic [$clog2(DEPTH+1)-1:0]   count_o,
    output logic                         full_o,
    output logic                         empty_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } ring_t;

    ring_t st_d, st_q;
    logic [W-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    assign full_o  = (st_q.cnt == CW'(DEPTH));
    assign empty_o = (st_q.cnt == '0);
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;
    assign head_o  = mem_q[st_q.rp];
    assign count_o = st_q.cnt;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (do_push) st_d.wp = bump(st_q.wp);
        if (do_pop)  st_d.rp = bump(st_q.rp);
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wp] <= data_i;
    end
endmodule

// File: rtl/spiq_mark.sv
module spiq_mark #(
    parameter int CW = 4
) (
    input  logic [CW-1:0] tx_cnt_i,
    input  logic [CW-1:0] rx_cnt_i,
    input  logic [CW-1:0] tx_mark_i,
    input  logic [CW-1:0] rx_mark_i,
    input  logic [1:0]    ien_i,
    output logic [1:0]    pend_o,
    output logic          irq_o
);
    import spiq_pkg::*;

    always_comb begin
        pend_o           = '0;
        pend_o[BIT_TXWM] = (tx_cnt_i < tx_mark_i);
        pend_o[BIT_RXWM] = (rx_cnt_i > rx_mark_i);
        irq_o            = |(pend_o & ien_i);
    end
endmodule

// File: rtl/spi_fifo_regs.sv
module spi_fifo_regs #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              irq
);
    import spiq_pkg::*;

    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [CW-1:0] txmark;
        logic [CW-1:0] rxmark;
        logic [1:0]    ien;
        logic [31:0]   rdata;
    } regs_t;

    regs_t r_d, r_q;
    reg_addr_e          a;
    logic [DATA_W-1:0]  rx_head;
    logic [CW-1:0]      tx_cnt, rx_cnt;
    logic               tx_full, tx_empty, rx_full, rx_empty;
    logic               tx_push, rx_pop;
    logic [1:0]         pend;
    logic [1:0]         ien_w;
    logic               unused_wdata;

    assign a            = reg_addr_e'(reg_addr);
    assign tx_push      = reg_wr && (a == A_TXD);
    assign rx_pop       = reg_rd && (a == A_RXD);
    assign tx_valid     = !tx_empty;
    assign rx_ready     = !rx_full;
    assign reg_rdata    = r_q.rdata;
    assign ien_w        = r_q.ien;
    assign unused_wdata = ^reg_wdata[31:DATA_W];

    spiq_ring #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push_i(tx_push), .data_i(reg_wdata[DATA_W-1:0]),
        .pop_i(tx_ready), .head_o(tx_data),
        .count_o(tx_cnt), .full_o(tx_full), .empty_o(tx_empty)
    );

    spiq_ring #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push_i(rx_valid), .data_i(rx_data),
        .pop_i(rx_pop), .head_o(rx_head),
        .count_o(rx_cnt), .full_o(rx_full), .empty_o(rx_empty)
    );

    spiq_mark #(.CW(CW)) u_mark (
        .tx_cnt_i(tx_cnt), .rx_cnt_i(rx_cnt),
        .tx_mark_i(r_q.txmark), .rx_mark_i(r_q.rxmark),
        .ien_i(r_q.ien), .pend_o(pend), .irq_o(irq)
    );

    always_comb begin
        r_d = r_q;
        if (reg_wr) begin
            case (a)
                A_TXMK:  r_d.txmark = reg_wdata[CW-1:0];
                A_RXMK:  r_d.rxmark = reg_wdata[CW-1:0];
                A_IEN:   r_d.ien    = reg_wdata[1:0];
                default: ;
            endcase
        end
        if (reg_rd) begin
            r_d.rdata = '0;
            case (a)
                A_TXD:  r_d.rdata[FLAG_BIT] = tx_full;
                A_RXD: begin
                    if (rx_empty) r_d.rdata[FLAG_BIT] = 1'b1;
                    else          r_d.rdata[DATA_W-1:0] = rx_head;
                end
                A_TXMK: r_d.rdata[CW-1:0] = r_q.txmark;
                A_RXMK: r_d.rdata[CW-1:0] = r_q.rxmark;
                A_IEN:  r_d.rdata[1:0]    = r_q.ien;
                A_IPND: r_d.rdata[1:0]    = pend;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/spiq_chk.sv
module spiq_chk #(
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic          reg_rd,
    input logic [2:0]    reg_addr,
    input logic [31:0]   reg_rdata,
    input logic          tx_valid,
    input logic          tx_ready,
    input logic          rx_valid,
    input logic          rx_ready,
    input logic          irq,
    input logic [CW-1:0] tx_cnt,
    input logic [CW-1:0] rx_cnt,
    input logic [1:0]    ien
);
    logic tx_push_ok, tx_pop_ok, rx_rd;
    assign tx_push_ok = reg_wr && (reg_addr == 3'd0) && (tx_cnt != CW'(DEPTH));
    assign tx_pop_ok  = tx_valid && tx_ready;
    assign rx_rd      = reg_rd && (reg_addr == 3'd1);

    // R4: queue levels never exceed the depth
    a_r4_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));

    // R1: write to a full queue with no pop leaves it full
    a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd0 && tx_cnt == CW'(DEPTH) && !tx_ready)
        |=> (tx_cnt == CW'(DEPTH)));

    // R10: simultaneous push and pop keep the count
    a_r10_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push_ok && tx_pop_ok) |=> (tx_cnt == $past(tx_cnt)));

    // R3: empty receive read flags bit 31 and pops nothing
    a_r3_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd && rx_cnt == '0 && !rx_valid) |=> (reg_rdata[31] && rx_cnt == '0));

    // R5: receive side accepts only when not full
    a_r5_rx_ready: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready == (rx_cnt != CW'(DEPTH)));

    // R8: interrupt needs an enable bit
    a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ien != 2'b00));
endmodule

bind spi_fifo_regs spiq_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_rdata(reg_rdata), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .irq(irq), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .ien(ien_w)
);

// File: tb/sim_spi_fifo_regs.sv
module sim_spi_fifo_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_valid, tx_ready = 1'b0;
    logic [7:0]  tx_data;
    logic        rx_valid = 1'b0, rx_ready;
    logic [7:0]  rx_data = '0;
    logic        irq;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    spi_fifo_regs u0 (.*);

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
    endtask

    task automatic rx_push(input logic [7:0] v);
        @(negedge clk); rx_valid = 1'b1; rx_data = v;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check(!irq, "R11 irq", 32'(irq), 0);
        check(!tx_valid && rx_ready, "R11 queues", {30'b0, tx_valid, rx_ready}, 1);
        rd(0, d); check(d == 0, "R2 tx not full", d, 0);
        rd(1, d); check(d == 32'h8000_0000, "R11 rx empty", d, 32'h8000_0000);
        rd(5, d); check(d == 0, "R11 pending", d, 0);
        rd(4, d); check(d == 0, "R11 enable", d, 0);
    endtask

    task automatic t_tx_fill;
        logic [31:0] d;
        for (int i = 0; i < 8; i++) wr(0, 32'hFFFF_FF10 + i);
        rd(0, d); check(d == 32'h8000_0000, "R2 tx full flag", d, 32'h8000_0000);
        wr(0, 32'hEE);
        for (int i = 0; i < 8; i++) begin
            check(tx_valid && tx_data == 8'(8'h10 + i), "R4 R5 tx order", {23'b0, tx_valid, tx_data}, 32'h110 + i);
            tx_ready = 1'b1;
            @(negedge clk); tx_ready = 1'b0;
        end
        check(!tx_valid, "R1 full write dropped", 32'(tx_valid), 0);
    endtask

    task automatic t_rx;
        logic [31:0] d;
        rx_push(8'h21); rx_push(8'h22); rx_push(8'h23);
        rd(1, d); check(d == 32'h21, "R3 rx pop 1", d, 32'h21);
        rd(1, d); check(d == 32'h22, "R3 rx pop 2", d, 32'h22);
        rd(1, d); check(d == 32'h23, "R3 rx pop 3", d, 32'h23);
        rd(1, d); check(d == 32'h8000_0000, "R3 rx empty read", d, 32'h8000_0000);
        rx_push(8'h5A);
        rd(1, d); check(d == 32'h5A, "R3 empty read did not pop", d, 32'h5A);
        for (int i = 0; i < 9; i++) rx_push(8'h40 + 8'(i));
        check(!rx_ready, "R5 rx_ready low when full", 32'(rx_ready), 0);
        for (int i = 0; i < 8; i++) begin
            rd(1, d); check(d == 32'h40 + i, "R4 rx order full", d, 32'h40 + i);
        end
        check(rx_ready, "R5 rx_ready after drain", 32'(rx_ready), 1);
    endtask

    task automatic t_marks;
        logic [31:0] d;
        wr(2, 3);
        rd(5, d); check(d == 1, "R6 tx below mark", d, 1);
        check(!irq, "R8 masked", 32'(irq), 0);
        wr(4, 1);
        check(irq, "R8 tx enabled", 32'(irq), 1);
        wr(0, 8'hA0); wr(0, 8'hA1);
        check(irq, "R6 count 2 below 3", 32'(irq), 1);
        wr(0, 8'hA2);
        rd(5, d); check(d == 0, "R6 count at mark", d, 0);
        check(!irq, "R8 irq clears", 32'(irq), 0);
        wr(5, 32'hFFFF_FFFF);
        rd(5, d); check(d == 0, "R9 pending write ignored", d, 0);
        wr(3, 1);
        rx_push(8'h31); rx_push(8'h32);
        rd(5, d); check(d == 2, "R7 rx above mark", d, 2);
        check(!irq, "R8 rx masked", 32'(irq), 0);
        wr(4, 3);
        check(irq, "R8 rx enabled", 32'(irq), 1);
        rd(1, d); check(d == 32'h31, "R3 rx pop", d, 32'h31);
        rd(5, d); check(d == 0, "R7 rx at mark", d, 0);
        rd(2, d); check(d == 3, "R12 tx mark readback", d, 3);
        rd(3, d); check(d == 1, "R12 rx mark readback", d, 1);
        rd(4, d); check(d == 3, "R12 enable readback", d, 3);
        rd(1, d); check(d == 32'h32, "R3 rx last", d, 32'h32);
    endtask

    task automatic t_simul;
        logic [31:0] d;
        int n;
        @(negedge clk);
        tx_ready = 1'b1; reg_wr = 1'b1; reg_addr = 0; reg_wdata = 8'hA3;
        @(negedge clk);
        tx_ready = 1'b0; reg_wr = 1'b0;
        rd(5, d); check(d[0] == 1'b0, "R10 count kept at 3", d, 0);
        n = 0;
        while (tx_valid && n < 10) begin
            check(tx_data == 8'(8'hA1 + n), "R10 R4 order after overlap", 32'(tx_data), 32'hA1 + n);
            tx_ready = 1'b1;
            @(negedge clk); tx_ready = 1'b0;
            n++;
        end
        check(n == 3, "R10 bytes drained", n, 3);
    endtask

    task automatic finish_up;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tx_fill();
        t_rx();
        t_marks();
        t_simul();
        finish_up();
    end
endmodule